// File: doc/BRIEF.md
# Sign-Magnitude Word Adder/Subtractor

This unit performs addition and subtraction on words held in sign-magnitude form. Each word has a separate sign bit and a magnitude of five 6-bit bytes, 31 bits in all. Because of this form there is a positive zero and a negative zero, and the range is symmetric about zero. An accumulator word and an operand word are presented together with an add/subtract select and a one-cycle start strobe. One clock later the unit registers the new accumulator value and raises a single-cycle done pulse.

If the true magnitude of the result does not fit in 30 bits, the unit keeps the low 30 bits and sets an overflow flag. The flag is sticky: later operations do not clear it. Only reset or an explicit clear input clears it, so a later conditional test can read it and then discard it. Subtraction flips the sign of the operand and then uses the same add path. The magnitude datapath can be built either with one shared subtractor and a conditional negate, or with two parallel subtractors, and a parameter selects the variant.

Top module: `smw_addsub`

## Requirements
- R1: Word layout: bit 30 is the sign (1 = negative) and bits 29:0 are the magnitude, made of five 6-bit bytes with the most significant byte in bits 29:24. Reset leaves `res_word` at +0 (all zero), `ovf_flag` at 0 and `done` at 0.
- R2: When `start` is high at a clock edge, `res_word` takes the new result at that edge and `done` is high for exactly the following cycle. Without `start`, `done` is 0.
- R3: With like effective signs the result magnitude is the sum of the magnitudes and the result sign is the common sign.
- R4: With unlike effective signs the smaller magnitude is subtracted from the larger, and the result takes the sign of the word with the larger magnitude.
- R5: `op_sub` = 0 selects add. `op_sub` = 1 selects subtract, which inverts the operand sign and then applies the add rules.
- R6: A zero result magnitude carries the sign of the accumulator input, including cases where both inputs are +0 or -0.
- R7: When the exact result magnitude exceeds 1,073,741,823, `res_word` keeps the low 30 bits of that magnitude with the common sign, and `ovf_flag` becomes 1.
- R8: `ovf_flag` is sticky: an operation that does not overflow leaves it unchanged.
- R9: `ovf_clear` clears `ovf_flag` at the next edge. If an overflowing operation starts in the same cycle, the set wins.
- R10: While `start` is low, changes on `acc_word`, `opd_word` and `op_sub` leave `res_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation on the current inputs |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| ovf_clear | input | 1 | Clear the sticky overflow flag |
| acc_word | input | 31 | Accumulator word (sign in bit 30) |
| opd_word | input | 31 | Operand word (sign in bit 30) |
| res_word | output | 31 | Registered result word |
| ovf_flag | output | 1 | Sticky overflow flag |
| done | output | 1 | One-cycle pulse after a started operation |

## Verification
The hardest case to reach from the ports is a start whose overflow falls in the same cycle as an overflow clear, together with an overflow whose low 30 bits are all zero. That second case must give a signed zero and still set the flag. The stimulus drives these cases directly: two maximum-magnitude words, a sum of exactly 2^30, and a clear asserted together with an overflowing start. It also mixes +0 and -0 under both operations. A random phase then weights magnitudes toward the top of the range and interleaves clears and idle cycles. Every cycle is compared against an integer reference model.

// File: rtl/smw_pkg.sv
`timescale 1ns/1ps
package smw_pkg;
   typedef enum logic {
      SMW_ADD = 1'b0,
      SMW_SUB = 1'b1
   } smw_op_e;
endpackage

// File: rtl/smw_sign_prep.sv
`timescale 1ns/1ps
module smw_sign_prep
   import smw_pkg::*;
(
   input  smw_op_e op,
   input  logic    opd_sign,
   output logic    eff_sign
);
   always_comb begin
      case (op)
         SMW_SUB: eff_sign = ~opd_sign;
         default: eff_sign = opd_sign;
      endcase
   end
endmodule

// File: rtl/smw_mag_unit.sv
`timescale 1ns/1ps
module smw_mag_unit #(
   parameter int MAG_W      = 30,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic             a_sign,
   input  logic [MAG_W-1:0] a_mag,
   input  logic             b_sign,
   input  logic [MAG_W-1:0] b_mag,
   output logic             r_sign,
   output logic [MAG_W-1:0] r_mag,
   output logic             r_ovf
);
   logic             like_signs;
   logic [MAG_W:0]   sum_ext;
   logic [MAG_W-1:0] diff_mag;
   logic             a_not_less;

   assign like_signs = (a_sign == b_sign);
   assign sum_ext    = {1'b0, a_mag} + {1'b0, b_mag};

   generate
      if (SHARED_SUB) begin : g_shared
         logic [MAG_W:0] raw;
         assign raw        = {1'b0, a_mag} - {1'b0, b_mag};
         assign a_not_less = ~raw[MAG_W];
         assign diff_mag   = raw[MAG_W] ? (~raw[MAG_W-1:0] + 1'b1) : raw[MAG_W-1:0];
      end else begin : g_parallel
         logic [MAG_W-1:0] a_minus_b;
         logic [MAG_W-1:0] b_minus_a;
         assign a_minus_b  = a_mag - b_mag;
         assign b_minus_a  = b_mag - a_mag;
         assign a_not_less = (a_mag >= b_mag);
         assign diff_mag   = a_not_less ? a_minus_b : b_minus_a;
      end
   endgenerate

   always_comb begin
      if (like_signs) begin
         r_sign = a_sign;
         r_mag  = sum_ext[MAG_W-1:0];
         r_ovf  = sum_ext[MAG_W];
      end else begin
         // equal magnitudes give a_not_less, so zero keeps the accumulator sign
         r_sign = a_not_less ? a_sign : b_sign;
         r_mag  = diff_mag;
         r_ovf  = 1'b0;
      end
   end
endmodule

// File: rtl/smw_addsub.sv
`timescale 1ns/1ps
module smw_addsub
   import smw_pkg::*;
#(
   parameter int BYTE_W     = 6,
   parameter int NUM_BYTES  = 5,
   parameter bit SHARED_SUB = 1'b1,
   localparam int MAG_W     = BYTE_W * NUM_BYTES,
   localparam int WORD_W    = MAG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_sub,
   input  logic              ovf_clear,
   input  logic [WORD_W-1:0] acc_word,
   input  logic [WORD_W-1:0] opd_word,
   output logic [WORD_W-1:0] res_word,
   output logic              ovf_flag,
   output logic              done
);
   generate
      if (BYTE_W < 1 || BYTE_W > 16) begin : g_bad_byte
         $error("smw_addsub: BYTE_W out of range");
      end
      if (NUM_BYTES < 1 || MAG_W > 62) begin : g_bad_count
         $error("smw_addsub: NUM_BYTES gives unsupported magnitude width");
      end
   endgenerate

   logic             eff_sign;
   logic             nxt_sign;
   logic [MAG_W-1:0] nxt_mag;
   logic             nxt_ovf;
   smw_op_e          op_sel;

   assign op_sel = smw_op_e'(op_sub);

   smw_sign_prep u_prep (
      .op       (op_sel),
      .opd_sign (opd_word[WORD_W-1]),
      .eff_sign (eff_sign)
   );

   smw_mag_unit #(
      .MAG_W      (MAG_W),
      .SHARED_SUB (SHARED_SUB)
   ) u_mag (
      .a_sign (acc_word[WORD_W-1]),
      .a_mag  (acc_word[MAG_W-1:0]),
      .b_sign (eff_sign),
      .b_mag  (opd_word[MAG_W-1:0]),
      .r_sign (nxt_sign),
      .r_mag  (nxt_mag),
      .r_ovf  (nxt_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_word <= '0;
         done     <= 1'b0;
      end else begin
         done <= start;
         if (start) res_word <= {nxt_sign, nxt_mag};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovf_flag <= 1'b0;
      else if (start && nxt_ovf)  ovf_flag <= 1'b1;
      else if (ovf_clear)         ovf_flag <= 1'b0;
   end

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));
   // R10
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(res_word));
   // R8
   sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clear) |=> ovf_flag);
   // R4
   unlike_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (acc_word[WORD_W-1] != eff_sign) && !ovf_flag) |=> !ovf_flag);
   // R6
   zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && acc_word[MAG_W-1:0] == '0 && opd_word[MAG_W-1:0] == '0)
      |=> (res_word == {$past(acc_word[WORD_W-1]), {MAG_W{1'b0}}}));
endmodule

// File: tb/test_smw_addsub.sv
`timescale 1ns/1ps
module test_smw_addsub;
   localparam longint MASK = (64'd1 << 30) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_sub = 1'b0;
   logic        ovf_clear = 1'b0;
   logic [30:0] acc_word = '0;
   logic [30:0] opd_word = '0;
   logic [30:0] res_word;
   logic        ovf_flag;
   logic        done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [30:0] exp_res = '0;
   bit          exp_ovf = 1'b0;
   bit          exp_done = 1'b0;

   always #5 clk = ~clk;

   smw_addsub i_smw_addsub (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
      .ovf_clear(ovf_clear), .acc_word(acc_word), .opd_word(opd_word),
      .res_word(res_word), .ovf_flag(ovf_flag), .done(done)
   );

   function automatic longint to_int(input logic [30:0] w);
      longint m = longint'(w[29:0]);
      return w[30] ? -m : m;
   endfunction

   // reference: exact integer arithmetic, then fold back to sign-magnitude
   task automatic model_edge();
      longint a, b, s, mag;
      bit sgn, ov;
      if (!rst_n) begin
         exp_res = '0; exp_ovf = 0; exp_done = 0;
         return;
      end
      exp_done = start;
      if (start) begin
         a = to_int(acc_word);
         b = to_int(opd_word);
         s = op_sub ? a - b : a + b;
         mag = (s < 0) ? -s : s;
         ov = (mag > MASK);
         if (s == 0) sgn = acc_word[30];
         else        sgn = (s < 0);
         exp_res = {sgn, 30'(mag & MASK)};
         if (ov) exp_ovf = 1;
         else if (ovf_clear) exp_ovf = 0;
      end else if (ovf_clear) begin
         exp_ovf = 0;
      end
   endtask

   task automatic compare(input string tag);
      checks++;
      if (res_word !== exp_res) begin
         failures++;
         $display("FAIL %s res_word actual=%h expected=%h", tag, res_word, exp_res);
      end
      checks++;
      if (ovf_flag !== exp_ovf) begin
         failures++;
         $display("FAIL %s ovf_flag actual=%b expected=%b", tag, ovf_flag, exp_ovf);
      end
      checks++;
      if (done !== exp_done) begin
         failures++;
         $display("FAIL %s done actual=%b expected=%b", tag, done, exp_done);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic op(input bit sub, input logic [30:0] a, input logic [30:0] b,
                     input bit clr, input string tag);
      start = 1; op_sub = sub; acc_word = a; opd_word = b; ovf_clear = clr;
      step(tag);
      start = 0; ovf_clear = 0;
   endtask

   function automatic logic [30:0] w(input bit s, input longint m);
      return {s, 30'(m)};
   endfunction

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      compare("R1 reset");
      rst_n = 1;
      step("R1 idle after reset");

      op(0, w(0, 100), w(0, 23), 0, "R3 add positives");
      step("R2 done drops");
      op(0, w(1, 500), w(1, 12), 0, "R3 add negatives");
      op(0, w(0, 500), w(1, 700), 0, "R4 larger operand sign");
      op(0, w(1, 900), w(0, 300), 0, "R4 larger accumulator sign");
      op(1, w(0, 50), w(0, 80), 0, "R5 sub gives negative");
      op(1, w(1, 50), w(1, 80), 0, "R5 sub of negatives");
      op(1, w(0, 7), w(1, 9), 0, "R5 sub negative operand");
      op(0, w(1, 0), w(0, 0), 0, "R6 -0 plus +0");
      op(0, w(0, 0), w(1, 0), 0, "R6 +0 plus -0");
      op(1, w(1, 0), w(1, 0), 0, "R6 -0 minus -0");
      op(0, w(1, 1234), w(0, 1234), 0, "R6 cancel negative acc");
      op(1, w(0, 77), w(0, 77), 0, "R6 cancel via sub");

      op(0, w(0, MASK), w(0, MASK), 0, "R7 max plus max");
      op(0, w(0, 5), w(0, 6), 0, "R8 sticky after plain add");
      op(1, w(0, 1), w(1, 2), 0, "R8 sticky after sub");
      ovf_clear = 1; step("R9 clear alone"); ovf_clear = 0;
      op(1, w(1, MASK), w(0, 1), 0, "R7 negative overflow");
      op(0, w(0, 64'd1 << 29), w(0, 64'd1 << 29), 1, "R9 set beats clear zero low bits");
      op(0, w(0, 3), w(0, 4), 1, "R9 clear with start no ovf");
      op(0, w(0, MASK - 1), w(0, 1), 0, "R7 exact max no overflow");

      acc_word = w(1, 999); opd_word = w(0, 5); op_sub = 1;
      step("R10 inputs change without start");
      acc_word = w(0, 1); op_sub = 0;
      step("R10 still held");

      for (int i = 0; i < 300; i++) begin
         longint ma = longint'($urandom) & MASK;
         longint mb = longint'($urandom) & MASK;
         if (i % 3 == 0) ma = ma | (longint'(MASK) & ~longint'(64'hFFFF));
         if (i % 5 == 0) mb = ma;
         if (i % 7 == 0) mb = 0;
         start = ($urandom % 10) < 7;
         op_sub = $urandom % 2;
         ovf_clear = ($urandom % 10) == 0;
         acc_word = w($urandom % 2, ma);
         opd_word = w($urandom % 2, mb);
         step("R5 random mix");
      end
      start = 0; ovf_clear = 0;
      step("R2 final idle");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule